// File: doc/BRIEF.md
# Ring and Reversal Envelope Detector

This block converts a line-event level into one clean, active-low envelope that a controller can use as a wake-up or interrupt source. The level comes from an analog comparator outside the block and is high while ringing voltage or a polarity reversal is present on the line. The block treats this level as asynchronous and synchronizes it first. It drives the envelope low while the level is high. After the level falls, it keeps the envelope low for a hold window that is counted in milliseconds. Every cycle in which the level is high restarts the window. Because of this, a ring waveform of roughly 25 Hz, whose pulses are separated by short gaps, becomes a single uninterrupted low pulse. A complete ring burst of a few hundred milliseconds therefore produces exactly one falling edge.

Setting the bypass control removes the hold from the output. The envelope then tracks the synchronized level only, so firmware can time the ringing directly. The hold counter keeps running in the background during bypass. The block has no enable or low-power input, so it stays active whenever its clock is running. The hold window is HOLD_MS times TICKS_PER_MS clock cycles. A typical setting is about 30 ms.

Top module: `ring_env_detector`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset is released with line_raw low, env_n is 1.
- R2: line_raw passes through two synchronizer flops and then an output register. A rise on line_raw that is first sampled at rising edge k sets env_n to 0 after edge k+2, and not earlier.
- R3: Every cycle in which the synchronized level is high drives env_n low on the next edge. The same cycle reloads the hold to its full length, so each new input pulse restarts the hold.
- R4: With bypass low, the synchronized level falls, and no new event arrives, env_n returns to 1 after rising edge HOLD_MS*TICKS_PER_MS+2. Edges are counted from the first edge at which line_raw is sampled low. This gives HOLD_MS*TICKS_PER_MS+1 low samples after the drop.
- R5: The millisecond prescaler is cleared on every cycle in which the synchronized level is high. The hold after the level falls is therefore an exact whole number of milliseconds and has no phase error.
- R6: An input that pulses periodically, with every low gap shorter than the hold window, gives exactly one falling edge on env_n for the whole burst. env_n returns to 1 after the burst.
- R7: Two events separated by a gap longer than the hold window give two separate low pulses on env_n.
- R8: With hold_bypass at 1, env_n is 0 only while the synchronized level is high. A pulse of N cycles on line_raw gives exactly N low cycles on env_n, with the same three-edge latency in both directions.
- R9: The hold counter keeps running while hold_bypass is 1. Clearing hold_bypass while part of the hold window remains drives env_n low on the next edge. env_n then stays low until the rest of the window has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_raw | input | 1 | Asynchronous line-event level; high while reversal or ringing is present |
| hold_bypass | input | 1 | 1: no hold, env_n follows the synchronized level |
| env_n | output | 1 | Active-low event envelope |

## Verification
A hold counter or prescaler that holds the wrong value changes when env_n rises after the input drops. The window comes out longer or shorter than HOLD_MS*TICKS_PER_MS cycles, and the reference model sees this in the same cycle the edge should have occurred. A missed reload shows up as a gap inside a ring burst: env_n rises in the middle of the burst and a second falling edge follows. A wrong number of synchronizer stages moves every transition of env_n by one cycle or more, so the first edge of the first event already shows it.

// File: rtl/env_pkg.sv
package env_pkg;
    // Width of a counter that must hold the value n (at least 1 bit).
    function automatic int cnt_width(input int n);
        int w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction
endpackage

// File: rtl/ring_env_sync.sv
module ring_env_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/ring_env_tick.sv
module ring_env_tick #(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int W = env_pkg::cnt_width(TICKS_PER_MS);
    localparam logic [W-1:0] LAST = W'(TICKS_PER_MS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    assign tick = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (restart || tick) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ring_env_hold.sv
module ring_env_hold #(
    parameter int HOLD_MS = 30,
    localparam int W = env_pkg::cnt_width(HOLD_MS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_s,
    input  logic         tick,
    input  logic         bypass,
    output logic         env_n,
    output logic [W-1:0] hold_cnt
);
    localparam logic [W-1:0] FULL = W'(HOLD_MS);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         env_n;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_s)                        st_d.cnt = FULL;
        else if (tick && st_q.cnt != '0)   st_d.cnt = st_q.cnt - 1'b1;
        st_d.env_n = ~(line_s | (~bypass & (st_d.cnt != '0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.env_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign env_n    = st_q.env_n;
    assign hold_cnt = st_q.cnt;
endmodule

// File: rtl/ring_env_detector.sv
module ring_env_detector #(
    parameter int TICKS_PER_MS = 1000,
    parameter int HOLD_MS      = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic hold_bypass,
    output logic env_n
);
    localparam int HW = env_pkg::cnt_width(HOLD_MS);

    logic          line_s;
    logic          tick;
    logic [HW-1:0] hold_cnt;

    ring_env_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_raw),
        .sync_out (line_s)
    );

    ring_env_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (line_s),
        .tick    (tick)
    );

    ring_env_hold #(.HOLD_MS(HOLD_MS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .tick     (tick),
        .bypass   (hold_bypass),
        .env_n    (env_n),
        .hold_cnt (hold_cnt)
    );
endmodule

// File: rtl/ring_env_checker.sv
module ring_env_checker #(
    parameter int TICKS_PER_MS = 1000,
    parameter int HOLD_MS      = 30,
    localparam int HW = env_pkg::cnt_width(HOLD_MS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_s,
    input logic          tick,
    input logic [HW-1:0] hold_cnt,
    input logic          bypass,
    input logic          env_n
);
    // R3: an active synchronized level pulls the envelope low next cycle
    assert_event_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> !env_n);

    // R3: each active cycle restarts the full hold
    assert_hold_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> (hold_cnt == HW'(HOLD_MS)));

    // R4: the hold never exceeds its programmed length
    assert_hold_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HW'(HOLD_MS));

    // R4: the envelope rises only after the level has gone and the hold has run out (or is bypassed)
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(env_n) |-> ($past(!line_s) && ($past(bypass) || hold_cnt == '0)));

    // R5: the millisecond enable is a single-cycle pulse
    assert_tick_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (TICKS_PER_MS > 1 && tick) |=> !tick);

    // R8: with bypass set and no event, the envelope is released next cycle
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !line_s) |=> env_n);
endmodule

bind ring_env_detector ring_env_checker #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .HOLD_MS      (HOLD_MS)
) u_ring_env_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .tick     (tick),
    .hold_cnt (hold_cnt),
    .bypass   (hold_bypass),
    .env_n    (env_n)
);

// File: tb/test_ring_env_detector.sv
module test_ring_env_detector;
    localparam int CLK_PERIOD   = 10;
    localparam int TICKS_PER_MS = 4;
    localparam int HOLD_MS      = 5;
    localparam int HOLD_CYC     = TICKS_PER_MS * HOLD_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_raw = 1'b0;
    logic hold_bypass = 1'b0;
    logic env_n;

    int vectors = 0;
    int miscompares = 0;
    int falls = 0;
    int lows = 0;
    bit prev_env = 1'b1;
    bit done = 1'b0;

    ring_env_detector #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .HOLD_MS      (HOLD_MS)
    ) i_ring_env_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_raw    (line_raw),
        .hold_bypass (hold_bypass),
        .env_n       (env_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference: delay line for the synchronizer, remaining-cycles integer for the hold
    bit dly[$] = '{1'b0, 1'b0};
    int remain = 0;
    bit m_env = 1'b1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly = '{1'b0, 1'b0};
            remain = 0;
            m_env = 1'b1;
        end else begin
            bit lvl;
            lvl = dly.pop_front();
            dly.push_back(line_raw);
            if (lvl) remain = HOLD_CYC;
            else if (remain > 0) remain--;
            m_env = !(lvl || (!hold_bypass && remain > 0));
        end
    end

    // Per-cycle comparison and edge counting, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (env_n !== m_env) begin
                miscompares++;
                $display("FAIL R2/R3/R4/R9 model cycle: env_n=%b expected=%b at %0t", env_n, m_env, $time);
            end
            if (prev_env && !env_n) falls++;
            if (!env_n) lows++;
            prev_env = env_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        wait_cyc(3);
        check(env_n == 1'b1, "R1 reset", env_n, 1);
        rst_n = 1'b1;
        wait_cyc(1);
        check(env_n == 1'b1, "R1 after release", env_n, 1);

        // R2: three-edge latency on a rise
        line_raw = 1'b1;
        wait_cyc(1); check(env_n == 1'b1, "R2 edge1", env_n, 1);
        wait_cyc(1); check(env_n == 1'b1, "R2 edge2", env_n, 1);
        wait_cyc(1); check(env_n == 1'b0, "R2 edge3", env_n, 0);
        wait_cyc(10);

        // R4 / R5: exact hold length after the drop
        line_raw = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (env_n) break;
            n++;
        end
        check(n == HOLD_CYC + 1, "R4/R5 hold length", n, HOLD_CYC + 1);
        wait_cyc(5);

        // R6 / R3: periodic ring burst merges into one envelope
        falls = 0;
        for (int p = 0; p < 12; p++) begin
            line_raw = 1'b1; wait_cyc(6);
            line_raw = 1'b0; wait_cyc(10);
        end
        wait_cyc(HOLD_CYC + 10);
        check(falls == 1, "R6/R3 single envelope", falls, 1);
        check(env_n == 1'b1, "R6 released", env_n, 1);

        // R7: long gap gives two envelopes
        falls = 0;
        line_raw = 1'b1; wait_cyc(5);
        line_raw = 1'b0; wait_cyc(HOLD_CYC + 20);
        line_raw = 1'b1; wait_cyc(5);
        line_raw = 1'b0; wait_cyc(HOLD_CYC + 10);
        check(falls == 2, "R7 two envelopes", falls, 2);

        // R8: bypass, envelope width equals pulse width
        hold_bypass = 1'b1;
        wait_cyc(2);
        lows = 0; falls = 0;
        line_raw = 1'b1; wait_cyc(8);
        line_raw = 1'b0; wait_cyc(10);
        check(lows == 8, "R8 bypass low count", lows, 8);
        check(falls == 1, "R8 bypass one pulse", falls, 1);
        check(env_n == 1'b1, "R8 bypass released", env_n, 1);

        // R9: clearing bypass while hold remains pulls the envelope low again
        line_raw = 1'b1; wait_cyc(6);
        line_raw = 1'b0; wait_cyc(5);
        check(env_n == 1'b1, "R9 high under bypass", env_n, 1);
        hold_bypass = 1'b0;
        wait_cyc(1);
        check(env_n == 1'b0, "R9 hold resumes", env_n, 0);
        wait_cyc(HOLD_CYC + 5);
        check(env_n == 1'b1, "R9 hold expires", env_n, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule